// File: doc/BRIEF.md
# Command Packet Register Replayer

This block parses one command packet that arrives as a stream of bytes, lowest address first, over a valid/ready handshake, after a start strobe. The first sixteen bytes are a header: a response slot, a control byte with three flags, a length byte, and two little-endian 32-bit pointers. The header is followed by a self-describing list of (value, address) byte pairs. The block replays these pairs as single-cycle writes on a disk-controller taskfile register port.

Each address byte carries two flags in its upper bits. One flag suppresses the write. The other flag marks the final pair. The length byte bounds the list. When the packet is finished, the block writes a response code for byte 0 of the packet on a separate port. That code reports success, a device error, or a protocol error. The decoded pointers and the data-phase flag are held on outputs for the data-movement logic that follows, and a completion interrupt is raised when the packet asks for one.

Top module: `cmdpkt_replayer`

## Requirements
- R1: After reset, in_ready, tf_we, rsp_we, irq and hdr_ok are all low and the block waits for start.
- R2: A start pulse while idle begins a packet, and in_ready is high only while header or pair bytes are being taken. A start pulse during a packet is ignored, and the packet completes unchanged.
- R3: Header byte 2 is decoded as bit 0 = valid, bit 2 = data phase (has_data) and bit 3 = interrupt request. Bytes 4..7 form next_ptr and bytes 8..11 form desc_ptr, least significant byte first. hdr_ok rises in the cycle after byte 15 is taken if the valid bit is set, and stays high until the next start.
- R4: Pairs start at byte 16 as value byte then address byte. In the cycle after each address byte is taken, tf_we pulses for one cycle with tf_addr = address bits 4..0 and tf_data = value. Writes come out in list order.
- R5: An address byte with bit 5 set produces no write.
- R6: An address byte with bit 7 set ends the list: no further bytes are taken and the response follows, and this holds even when bit 5 is also set.
- R7: The pair area holds length×8 bytes (length = header byte 3). If its last address byte is taken without bit 7, or if length is 0 on a valid packet, the packet ends with a protocol error. Writes already issued stay issued.
- R8: A packet whose valid bit is clear issues no writes and ends with a protocol error after its 16 header bytes.
- R9: rsp_we pulses for one cycle in the cycle after the final byte of a packet is taken. rsp_data is 0x01 on success, 0x08 if dev_err is high in that cycle, and 0x02 on a protocol error; a protocol error takes precedence over dev_err.
- R10: irq pulses together with rsp_we when the packet's valid and interrupt bits are both set, and stays low otherwise.
- R11: When the final pair both ends the list and writes, its taskfile write and the response strobe occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin parsing a packet |
| in_data | input | 8 | Packet byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Byte is taken when in_valid and in_ready are both high |
| dev_err | input | 1 | Device reported an error, sampled in the response cycle |
| tf_we | output | 1 | Taskfile register write strobe |
| tf_addr | output | 5 | Taskfile register address |
| tf_data | output | 8 | Taskfile register value |
| hdr_ok | output | 1 | Header of a valid packet decoded |
| next_ptr | output | 32 | Next packet address |
| desc_ptr | output | 32 | Data descriptor list address |
| has_data | output | 1 | Packet has a data phase |
| rsp_we | output | 1 | Response byte write strobe |
| rsp_data | output | 8 | Response byte |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Two things can land in one cycle. The first is the final taskfile write and the response strobe, when the list-ending pair also writes. The bench provokes this with a command pair carrying the end flag and confirms that both strobes are seen at the same sampling point, with the command value and a success code. The second is end-of-list and length exhaustion on the very same byte. The bench places the end flag on the last pair slot the length allows and expects success, not a protocol error. A companion case omits the flag and expects the protocol error.

// File: rtl/cpkt_pkg.sv
package cpkt_pkg;

    localparam int BYTE_W     = 8;
    localparam int HDR_BYTES  = 16;
    localparam int HDR_IDX_W  = $clog2(HDR_BYTES);
    localparam int TF_AW      = 5;

    // header byte positions
    localparam int OFS_CTRL   = 2;
    localparam int OFS_LEN    = 3;
    localparam int OFS_NEXT   = 4;
    localparam int OFS_DESC   = 8;

    // control byte flags
    localparam int CF_VALID   = 0;
    localparam int CF_DATA    = 2;
    localparam int CF_IRQ     = 3;

    // address byte flags
    localparam int AF_SKIP    = 5;
    localparam int AF_END     = 7;

    // response bits
    localparam int RSP_DONE   = 0;
    localparam int RSP_PERR   = 1;
    localparam int RSP_DERR   = 3;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_HDR   = 2'd1,
        PS_PAIRS = 2'd2,
        PS_RESP  = 2'd3
    } pstate_e;

    typedef struct packed {
        logic irq_en;
        logic has_data;
        logic valid;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.valid    = b[CF_VALID];
        c.has_data = b[CF_DATA];
        c.irq_en   = b[CF_IRQ];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] rsp_code(input logic perr, input logic derr);
        logic [BYTE_W-1:0] r;
        r = '0;
        if (perr)
            r[RSP_PERR] = 1'b1;
        else if (derr)
            r[RSP_DERR] = 1'b1;
        else
            r[RSP_DONE] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/cpkt_hdr.sv
module cpkt_hdr
    import cpkt_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int LEN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc,
    input  logic [HDR_IDX_W-1:0] idx,
    input  logic [BYTE_W-1:0]    data,
    output ctrl_t                ctrl,
    output logic [LEN_W-1:0]     len,
    output logic [PTR_W-1:0]     next_ptr,
    output logic [PTR_W-1:0]     desc_ptr
);
    localparam int PTR_BYTES = PTR_W / BYTE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            len  <= '0;
        end else if (acc) begin
            if (idx == HDR_IDX_W'(OFS_CTRL))
                ctrl <= decode_ctrl(data);
            if (idx == HDR_IDX_W'(OFS_LEN))
                len <= LEN_W'(data);
        end
    end

    for (genvar g = 0; g < PTR_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                next_ptr[g*BYTE_W +: BYTE_W] <= '0;
                desc_ptr[g*BYTE_W +: BYTE_W] <= '0;
            end else if (acc) begin
                if (idx == HDR_IDX_W'(OFS_NEXT + g))
                    next_ptr[g*BYTE_W +: BYTE_W] <= data;
                if (idx == HDR_IDX_W'(OFS_DESC + g))
                    desc_ptr[g*BYTE_W +: BYTE_W] <= data;
            end
        end
    end

endmodule

// File: rtl/cpkt_walk.sv
module cpkt_walk
    import cpkt_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LEN_W-1:0]  len,
    input  logic              acc,
    input  logic [BYTE_W-1:0] data,
    output logic              addr_phase,
    output logic              fin_end,
    output logic              fin_over,
    output logic              tf_we,
    output logic [TF_AW-1:0]  tf_addr,
    output logic [BYTE_W-1:0] tf_data
);
    // pairs per 8-byte unit
    localparam int CNT_W = LEN_W + 2;

    logic              phase;
    logic [CNT_W-1:0]  rem;
    logic [BYTE_W-1:0] val;

    assign addr_phase = phase;
    assign fin_end    = acc && phase && data[AF_END];
    assign fin_over   = acc && phase && !data[AF_END] && (rem == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= 1'b0;
            rem     <= '0;
            val     <= '0;
            tf_we   <= 1'b0;
            tf_addr <= '0;
            tf_data <= '0;
        end else begin
            tf_we <= 1'b0;
            if (load) begin
                phase <= 1'b0;
                rem   <= {len, 2'b00};
            end else if (acc) begin
                phase <= ~phase;
                if (!phase) begin
                    val <= data;
                end else begin
                    rem <= rem - CNT_W'(1);
                    if (!data[AF_SKIP]) begin
                        tf_we   <= 1'b1;
                        tf_addr <= data[TF_AW-1:0];
                        tf_data <= val;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cpkt_seq.sv
module cpkt_seq
    import cpkt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 in_valid,
    input  ctrl_t                ctrl,
    input  logic                 len_zero,
    input  logic                 fin_end,
    input  logic                 fin_over,
    input  logic                 dev_err,
    output logic                 in_ready,
    output logic                 hdr_acc,
    output logic                 pair_acc,
    output logic                 load,
    output logic [HDR_IDX_W-1:0] idx,
    output logic                 hdr_ok,
    output logic                 rsp_we,
    output logic [BYTE_W-1:0]    rsp_data,
    output logic                 irq
);
    localparam logic [HDR_IDX_W-1:0] IDX_LAST = HDR_IDX_W'(HDR_BYTES - 1);

    pstate_e state;
    logic    perr;
    logic    hdr_last;

    assign in_ready = (state == PS_HDR) || (state == PS_PAIRS);
    assign hdr_acc  = in_valid && (state == PS_HDR);
    assign pair_acc = in_valid && (state == PS_PAIRS);
    assign hdr_last = hdr_acc && (idx == IDX_LAST);
    assign load     = hdr_last && ctrl.valid && !len_zero;
    assign rsp_we   = (state == PS_RESP);
    assign rsp_data = rsp_code(perr, dev_err);
    assign irq      = rsp_we && ctrl.valid && ctrl.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PS_IDLE;
            idx    <= '0;
            perr   <= 1'b0;
            hdr_ok <= 1'b0;
        end else begin
            unique case (state)
                PS_IDLE: begin
                    if (start) begin
                        state  <= PS_HDR;
                        idx    <= '0;
                        perr   <= 1'b0;
                        hdr_ok <= 1'b0;
                    end
                end
                PS_HDR: begin
                    if (hdr_acc) begin
                        idx <= idx + HDR_IDX_W'(1);
                        if (hdr_last) begin
                            hdr_ok <= ctrl.valid;
                            if (load) begin
                                state <= PS_PAIRS;
                            end else begin
                                state <= PS_RESP;
                                perr  <= 1'b1;
                            end
                        end
                    end
                end
                PS_PAIRS: begin
                    if (fin_end) begin
                        state <= PS_RESP;
                    end else if (fin_over) begin
                        state <= PS_RESP;
                        perr  <= 1'b1;
                    end
                end
                PS_RESP: state <= PS_IDLE;
                default: state <= PS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmdpkt_replayer.sv
module cmdpkt_replayer
    import cpkt_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              dev_err,
    output logic              tf_we,
    output logic [4:0]        tf_addr,
    output logic [7:0]        tf_data,
    output logic              hdr_ok,
    output logic [PTR_W-1:0]  next_ptr,
    output logic [PTR_W-1:0]  desc_ptr,
    output logic              has_data,
    output logic              rsp_we,
    output logic [7:0]        rsp_data,
    output logic              irq
);
    ctrl_t                ctrl;
    logic [LEN_W-1:0]     len;
    logic [HDR_IDX_W-1:0] idx;
    logic                 hdr_acc;
    logic                 pair_acc;
    logic                 load;
    logic                 fin_end;
    logic                 fin_over;
    logic                 pair_phase;

    assign has_data = ctrl.has_data;

    cpkt_hdr #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_hdr (
        .clk      (clk),
        .rst      (rst),
        .acc      (hdr_acc),
        .idx      (idx),
        .data     (in_data),
        .ctrl     (ctrl),
        .len      (len),
        .next_ptr (next_ptr),
        .desc_ptr (desc_ptr)
    );

    cpkt_walk #(.LEN_W(LEN_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .len        (len),
        .acc        (pair_acc),
        .data       (in_data),
        .addr_phase (pair_phase),
        .fin_end    (fin_end),
        .fin_over   (fin_over),
        .tf_we      (tf_we),
        .tf_addr    (tf_addr),
        .tf_data    (tf_data)
    );

    cpkt_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .ctrl     (ctrl),
        .len_zero (len == '0),
        .fin_end  (fin_end),
        .fin_over (fin_over),
        .dev_err  (dev_err),
        .in_ready (in_ready),
        .hdr_acc  (hdr_acc),
        .pair_acc (pair_acc),
        .load     (load),
        .idx      (idx),
        .hdr_ok   (hdr_ok),
        .rsp_we   (rsp_we),
        .rsp_data (rsp_data),
        .irq      (irq)
    );

endmodule

// File: rtl/cmdpkt_replayer_chk.sv
module cmdpkt_replayer_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic       pair_phase,
    input logic       tf_we,
    input logic       hdr_ok,
    input logic       rsp_we,
    input logic [7:0] rsp_data,
    input logic       irq
);
    logic addr_take;
    assign addr_take = in_valid && in_ready && pair_phase;

    p_write_follows_addr_r4: assert property (@(posedge clk) disable iff (rst)
        tf_we |-> $past(addr_take));

    p_skip_no_write_r5: assert property (@(posedge clk) disable iff (rst)
        (addr_take && in_data[5]) |=> !tf_we);

    p_end_stops_r6: assert property (@(posedge clk) disable iff (rst)
        (addr_take && in_data[7]) |=> (rsp_we && !in_ready));

    p_write_needs_hdr_r8: assert property (@(posedge clk) disable iff (rst)
        tf_we |-> hdr_ok);

    p_rsp_single_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_we |=> !rsp_we);

    p_rsp_code_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_we |-> ($countones(rsp_data) == 1));

    p_irq_in_rsp_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> rsp_we);

endmodule

bind cmdpkt_replayer cmdpkt_replayer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .pair_phase (pair_phase),
    .tf_we      (tf_we),
    .hdr_ok     (hdr_ok),
    .rsp_we     (rsp_we),
    .rsp_data   (rsp_data),
    .irq        (irq)
);

// File: tb/cmdpkt_replayer_tb.sv
`timescale 1ns/1ps
module cmdpkt_replayer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        dev_err = 1'b0;
    logic        tf_we;
    logic [4:0]  tf_addr;
    logic [7:0]  tf_data;
    logic        hdr_ok;
    logic [31:0] next_ptr;
    logic [31:0] desc_ptr;
    logic        has_data;
    logic        rsp_we;
    logic [7:0]  rsp_data;
    logic        irq;

    always #4 clk = ~clk;

    cmdpkt_replayer u_dut (
        .clk(clk), .rst(rst), .start(start), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .dev_err(dev_err),
        .tf_we(tf_we), .tf_addr(tf_addr), .tf_data(tf_data),
        .hdr_ok(hdr_ok), .next_ptr(next_ptr), .desc_ptr(desc_ptr),
        .has_data(has_data), .rsp_we(rsp_we), .rsp_data(rsp_data), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    // packet image
    logic [7:0] pk [0:63];
    int         pk_n;

    // observation log
    logic [4:0] lg_a [0:31];
    logic [7:0] lg_d [0:31];
    int         wr_n;
    int         rsp_n;
    logic [7:0] rsp_v;
    int         irq_n;
    logic       coinc;

    always @(negedge clk) begin
        if (!rst) begin
            if (tf_we) begin
                if (wr_n < 32) begin
                    lg_a[wr_n] = tf_addr;
                    lg_d[wr_n] = tf_data;
                end
                wr_n = wr_n + 1;
            end
            if (rsp_we) begin
                rsp_n = rsp_n + 1;
                rsp_v = rsp_data;
                if (tf_we) coinc = 1'b1;
            end
            if (irq) irq_n = irq_n + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_log();
        wr_n = 0; rsp_n = 0; rsp_v = 8'h00; irq_n = 0; coinc = 1'b0;
    endtask

    task automatic build_hdr(input logic [7:0] ctrl, input logic [7:0] len,
                             input logic [31:0] np, input logic [31:0] dp);
        for (int i = 0; i < 64; i++) pk[i] = 8'h00;
        pk[2] = ctrl;
        pk[3] = len;
        for (int i = 0; i < 4; i++) begin
            pk[4+i] = np[8*i +: 8];
            pk[8+i] = dp[8*i +: 8];
        end
        pk_n = 16;
    endtask

    task automatic add_pair(input logic [7:0] v, input logic [7:0] a);
        pk[pk_n]   = v;
        pk[pk_n+1] = a;
        pk_n = pk_n + 2;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic send_range(input int first, input int last, input int gap);
        for (int i = first; i <= last; i++) begin
            for (int g = 0; g < gap; g++) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pk[i];
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1 in_valid = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic run_pkt(input int gap);
        clr_log();
        pulse_start();
        send_range(0, pk_n - 1, gap);
        settle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 in_ready", in_ready, 0);
        check("R1 tf_we", tf_we, 0);
        check("R1 rsp_we", rsp_we, 0);
        check("R1 irq", irq, 0);
        check("R1 hdr_ok", hdr_ok, 0);
    endtask

    task automatic t_lba28();
        build_hdr(8'h0D, 8'd2, 32'h12345678, 32'hA0B0C0D0);
        add_pair(8'hE0, 8'h16); add_pair(8'h08, 8'h12);
        add_pair(8'h11, 8'h13); add_pair(8'h22, 8'h14);
        add_pair(8'h33, 8'h15); add_pair(8'h00, 8'h0E);
        add_pair(8'h5A, 8'h20); add_pair(8'hC8, 8'h97);
        run_pkt(1);
        check("R3 next_ptr", next_ptr, 32'h12345678);
        check("R3 desc_ptr", desc_ptr, 32'hA0B0C0D0);
        check("R3 hdr_ok", hdr_ok, 1);
        check("R3 has_data", has_data, 1);
        check("R5 write count with skip", wr_n, 7);
        check("R4 first addr", lg_a[0], 5'h16);
        check("R4 first data", lg_d[0], 8'hE0);
        check("R4 addr 5", lg_a[5], 5'h0E);
        check("R4 cmd addr masked", lg_a[6], 5'h17);
        check("R4 cmd data", lg_d[6], 8'hC8);
        check("R9 success code", rsp_v, 8'h01);
        check("R9 single rsp", rsp_n, 1);
        check("R10 irq", irq_n, 1);
        check("R11 write with rsp", coinc, 1);
        check("R2 idle not ready", in_ready, 0);
    endtask

    task automatic t_lba48_exact();
        build_hdr(8'h01, 8'd3, 32'h00000040, 32'hFFEE0010);
        add_pair(8'h40, 8'h16); add_pair(8'h00, 8'h12);
        add_pair(8'h01, 8'h13); add_pair(8'h02, 8'h14);
        add_pair(8'h03, 8'h15); add_pair(8'h10, 8'h12);
        add_pair(8'h20, 8'h13); add_pair(8'h30, 8'h14);
        add_pair(8'h40, 8'h15); add_pair(8'h00, 8'h0E);
        add_pair(8'h20, 8'h20); add_pair(8'h25, 8'h97);
        run_pkt(0);
        check("R7 end at last slot writes", wr_n, 11);
        check("R7 end at last slot is success", rsp_v, 8'h01);
        check("R4 hob lbal", lg_d[2], 8'h01);
        check("R4 lbah addr", lg_a[8], 5'h15);
        check("R3 no data phase", has_data, 0);
        check("R3 desc_ptr", desc_ptr, 32'hFFEE0010);
        check("R10 no irq", irq_n, 0);
    endtask

    task automatic t_dev_err();
        build_hdr(8'h05, 8'd1, 32'h1, 32'h2);
        add_pair(8'hA0, 8'h16); add_pair(8'h01, 8'h12);
        add_pair(8'h00, 8'h20); add_pair(8'hEC, 8'h97);
        dev_err = 1'b1;
        run_pkt(0);
        dev_err = 1'b0;
        check("R9 device error code", rsp_v, 8'h08);
        check("R5 writes", wr_n, 3);
        check("R4 command data", lg_d[2], 8'hEC);
    endtask

    task automatic t_invalid();
        build_hdr(8'h0C, 8'd2, 32'h55, 32'h66);
        run_pkt(0);
        check("R8 no writes", wr_n, 0);
        check("R8 protocol error", rsp_v, 8'h02);
        check("R8 hdr_ok low", hdr_ok, 0);
        check("R10 no irq invalid", irq_n, 0);
        check("R8 not ready after", in_ready, 0);
    endtask

    task automatic t_no_end();
        build_hdr(8'h09, 8'd1, 32'h7, 32'h8);
        add_pair(8'h11, 8'h12); add_pair(8'h22, 8'h13);
        add_pair(8'h33, 8'h14); add_pair(8'h44, 8'h15);
        dev_err = 1'b1;
        run_pkt(0);
        dev_err = 1'b0;
        check("R7 writes kept", wr_n, 4);
        check("R7 overrun protocol error over dev_err", rsp_v, 8'h02);
        check("R10 irq on error", irq_n, 1);
        check("R7 not ready after", in_ready, 0);
    endtask

    task automatic t_len_zero();
        build_hdr(8'h01, 8'd0, 32'h9, 32'hA);
        run_pkt(0);
        check("R7 len0 no writes", wr_n, 0);
        check("R7 len0 protocol error", rsp_v, 8'h02);
        check("R3 len0 hdr_ok", hdr_ok, 1);
    endtask

    task automatic t_start_busy();
        build_hdr(8'h01, 8'd1, 32'hCAFE0123, 32'h0BAD0456);
        add_pair(8'hA0, 8'h16); add_pair(8'h01, 8'h12);
        add_pair(8'h00, 8'h20); add_pair(8'hEC, 8'h97);
        clr_log();
        pulse_start();
        send_range(0, 5, 0);
        pulse_start();
        send_range(6, pk_n - 1, 0);
        settle();
        check("R2 ignored start ptr", next_ptr, 32'hCAFE0123);
        check("R2 ignored start writes", wr_n, 3);
        check("R2 ignored start rsp", rsp_v, 8'h01);
        check("R2 ignored start one rsp", rsp_n, 1);
    endtask

    task automatic t_skip_end();
        build_hdr(8'h01, 8'd1, 32'h3, 32'h4);
        add_pair(8'hE0, 8'h16); add_pair(8'h99, 8'hA0);
        run_pkt(0);
        check("R6 skip+end writes", wr_n, 1);
        check("R6 skip+end success", rsp_v, 8'h01);
        check("R6 stopped taking bytes", in_ready, 0);
        check("R11 no write with rsp", coinc, 0);
    endtask

    initial begin
        clr_log();
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lba28();
        t_lba48_exact();
        t_dev_err();
        t_invalid();
        t_no_end();
        t_len_zero();
        t_start_busy();
        t_skip_end();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule